// File: doc/BRIEF.md
# Minimal 8-bit Processor Core with a Fixed Opcode Subset

This block is a small multi-cycle 8-bit processor that executes a fixed handful of opcodes against one byte-wide memory. Memory reads are synchronous with one cycle of latency: the core presents an address in one cycle and consumes the returned byte in the next. Every memory access occupies one state. Immediate operands are read from consecutive addresses that follow the opcode.

The supported work is:

- loading 16-bit immediates into the HL pair or the stack pointer;
- incrementing the accumulator, with flag updates;
- jumping to an immediate address or to the address held in HL;
- calling a subroutine, which pushes a two-byte return address;
- clearing the interrupt enable bit;
- testing bit 7 of the byte that HL points to, through a second opcode page that a prefix byte selects.

An opcode outside this set, on either page, drops the core into a trap state. The trap holds for good and raises a fault output.

A one-cycle retire pulse marks every completed instruction and carries the address of that instruction. The accumulator, flags, HL, stack pointer and interrupt enable bit are brought out as plain outputs. Together these let a testbench step a program through a behavioural memory and compare the core, instruction by instruction, with a model.

Top module: `tiny8_core`

## Requirements
- R1: Reset state. While reset is asserted, and until the first clock edge after its release:
  - the program counter is 0x0100 and `mem_addr` equals it;
  - the stack pointer is 0xDFFF;
  - the accumulator, H, L and all flags are zero;
  - the interrupt enable bit is 1;
  - `retire`, `mem_we` and `fault` are low.
- R2: Opcode 0x00 changes no architectural state other than the program counter, which advances by 1. Opcode 0xF3 clears the interrupt enable bit and otherwise behaves like 0x00.
- R3: Opcode 0x21 reads two immediate bytes. The first goes into L and the second into H. The program counter advances by 3.
- R4: Opcode 0x31 loads the stack pointer with a little-endian 16-bit immediate: low byte first, high byte second. The program counter advances by 3.
- R5: Opcode 0x3C adds 1 to the accumulator, modulo 256. The flag byte holds Z in bit 7, N in bit 6, H in bit 5 and C in bit 4; bits 3 to 0 always read 0. The flags update as follows:
  - Z is set exactly when the result is 0x00;
  - N is cleared;
  - H is set exactly when the low nibble of the result is 0;
  - C keeps its value.
- R6: Opcode 0xC3 loads the program counter with a little-endian immediate. Opcode 0xE9 loads it with {H, L}.
- R7: Opcode 0xCD performs a call, in this order:
  - it writes the high byte of (opcode address + 3) to SP-1;
  - it writes the low byte to SP-2, in the next cycle;
  - it leaves SP lowered by 2;
  - it jumps to its little-endian immediate.
- R8: The prefix byte 0xCB is followed by a second-page opcode. Second-page opcode 0x7E reads the byte at address {H, L} and sets the flags as follows:
  - Z is the inverse of that byte's bit 7;
  - N is cleared;
  - H is set;
  - C keeps its value.
  The program counter advances by 2.
- R9: An opcode outside the supported set, on the first or the second page, moves the core into a trap state. In that state:
  - `fault` is high and stays high until reset;
  - no instruction retires;
  - no memory write occurs.
- R10: `retire` is high for exactly one cycle per completed instruction. In that cycle `retire_pc` holds the address of the instruction's opcode byte, and the state outputs already show that instruction's results.
- R11: Memory reads take one cycle. The byte on `mem_rdata` answers the address driven on `mem_addr` one cycle earlier. Operand bytes are fetched from the addresses that directly follow the opcode, in increasing order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Memory address for the current access |
| mem_rdata | input | 8 | Read data for the address driven in the previous cycle |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe; the write lands at the clock edge |
| retire | output | 1 | One-cycle pulse per completed instruction |
| retire_pc | output | 16 | Opcode address of the retiring instruction |
| fault | output | 1 | High in the trap state |
| a_out | output | 8 | Accumulator |
| f_out | output | 8 | Flag byte (Z,N,H,C in bits 7..4) |
| hl_out | output | 16 | H and L pair, H in the upper byte |
| sp_out | output | 16 | Stack pointer |
| ime_out | output | 1 | Interrupt enable bit |

## Verification
The bench runs the accumulator through a full 256-step wrap, which covers the 0x0F to 0x10 half-carry and the 0xFF to 0x00 zero case. A core that tested the operand's nibble instead of the result's, or that let carry move, diverges from the model at the first such step.

A call with a known stack pointer is checked byte by byte in memory. Swapped push order or an off-by-one stack address shows up as the wrong bytes at 0xCFFF and 0xCFFE, or as a wrong return value.

Undefined opcodes on both pages must raise `fault` with no retire and no write afterwards; a core that skipped them would keep retiring. Seeded random programs then mix every opcode, including register-indirect jumps and bit tests on random data. These catch wrong immediate byte order and stale reads that come from mistimed bus latency.

// File: rtl/tiny8_pkg.sv
package tiny8_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_IMM_LO,
        ST_IMM_HI,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_CB_DEC,
        ST_BIT_ADDR,
        ST_BIT_EXE,
        ST_TRAP
    } state_e;

    typedef enum logic [3:0] {
        OP_NOP,
        OP_LD_HL,
        OP_LD_SP,
        OP_INC_A,
        OP_JP_IMM,
        OP_JP_HL,
        OP_CALL,
        OP_DI,
        OP_PREFIX,
        OP_BAD
    } op_e;

    // Packed so that z..c map straight onto flag-byte bits 7..4
    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

endpackage

// File: rtl/tiny8_decode.sv
module tiny8_decode
    import tiny8_pkg::*;
(
    input  logic [DATA_W-1:0] opcode,
    output op_e               op,
    output logic              page2_bit7_hl
);

    always_comb begin
        unique case (opcode)
            8'h00:   op = OP_NOP;
            8'h21:   op = OP_LD_HL;
            8'h31:   op = OP_LD_SP;
            8'h3C:   op = OP_INC_A;
            8'hC3:   op = OP_JP_IMM;
            8'hE9:   op = OP_JP_HL;
            8'hCD:   op = OP_CALL;
            8'hF3:   op = OP_DI;
            8'hCB:   op = OP_PREFIX;
            default: op = OP_BAD;
        endcase
    end

    // Second page: only the bit-7 test through HL is defined
    assign page2_bit7_hl = (opcode == 8'h7E);

endmodule

// File: rtl/tiny8_alu.sv
module tiny8_alu
    import tiny8_pkg::*;
(
    input  logic [DATA_W-1:0] acc_in,
    input  flags_t            flags_in,
    input  logic [DATA_W-1:0] mem_byte,
    output logic [DATA_W-1:0] inc_res,
    output flags_t            inc_flags,
    output flags_t            bit_flags
);

    always_comb begin
        inc_res     = acc_in + 8'd1;
        inc_flags.z = (inc_res == '0);
        inc_flags.n = 1'b0;
        inc_flags.h = (inc_res[3:0] == 4'h0);
        inc_flags.c = flags_in.c;

        bit_flags.z = ~mem_byte[DATA_W-1];
        bit_flags.n = 1'b0;
        bit_flags.h = 1'b1;
        bit_flags.c = flags_in.c;
    end

endmodule

// File: rtl/tiny8_addr_sel.sv
module tiny8_addr_sel
    import tiny8_pkg::*;
(
    input  state_e            state,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] sp,
    input  logic [ADDR_W-1:0] hl,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              we
);

    always_comb begin
        addr  = pc;
        wdata = '0;
        we    = 1'b0;
        unique case (state)
            ST_PUSH_HI: begin
                addr  = sp - 16'd1;
                wdata = pc[ADDR_W-1:DATA_W];
                we    = 1'b1;
            end
            ST_PUSH_LO: begin
                addr  = sp - 16'd1;
                wdata = pc[DATA_W-1:0];
                we    = 1'b1;
            end
            ST_BIT_ADDR: addr = hl;
            default:     addr = pc;
        endcase
    end

endmodule

// File: rtl/tiny8_core.sv
module tiny8_core
    import tiny8_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC  = 16'h0100,
    parameter logic [ADDR_W-1:0] RESET_SP  = 16'hDFFF,
    parameter logic              RESET_IME = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              retire,
    output logic [ADDR_W-1:0] retire_pc,
    output logic              fault,
    output logic [DATA_W-1:0] a_out,
    output logic [DATA_W-1:0] f_out,
    output logic [ADDR_W-1:0] hl_out,
    output logic [ADDR_W-1:0] sp_out,
    output logic              ime_out
);

    localparam int FLAG_PAD = DATA_W - $bits(flags_t);

    typedef struct packed {
        state_e            state;
        op_e               op;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] sp;
        logic [ADDR_W-1:0] ipc;
        logic [ADDR_W-1:0] retire_pc;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] h;
        logic [DATA_W-1:0] l;
        logic [DATA_W-1:0] imm_lo;
        logic [DATA_W-1:0] imm_hi;
        flags_t            flags;
        logic              ime;
        logic              retire;
    } core_t;

    core_t s_d, s_q;

    op_e               dec_op;
    logic              dec_bit7;
    logic [DATA_W-1:0] inc_res;
    flags_t            inc_flags;
    flags_t            bit_flags;

    tiny8_decode u_decode (
        .opcode        (mem_rdata),
        .op            (dec_op),
        .page2_bit7_hl (dec_bit7)
    );

    tiny8_alu u_alu (
        .acc_in    (s_q.a),
        .flags_in  (s_q.flags),
        .mem_byte  (mem_rdata),
        .inc_res   (inc_res),
        .inc_flags (inc_flags),
        .bit_flags (bit_flags)
    );

    tiny8_addr_sel u_addr (
        .state (s_q.state),
        .pc    (s_q.pc),
        .sp    (s_q.sp),
        .hl    ({s_q.h, s_q.l}),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .we    (mem_we)
    );

    function automatic core_t finish(core_t c);
        core_t r;
        r           = c;
        r.retire    = 1'b1;
        r.retire_pc = c.ipc;
        r.state     = ST_FETCH;
        return r;
    endfunction

    always_comb begin
        s_d        = s_q;
        s_d.retire = 1'b0;
        unique case (s_q.state)
            ST_FETCH: begin
                s_d.ipc   = s_q.pc;
                s_d.pc    = s_q.pc + 16'd1;
                s_d.state = ST_DECODE;
            end
            ST_DECODE: begin
                s_d.op = dec_op;
                unique case (dec_op)
                    OP_NOP: s_d = finish(s_d);
                    OP_DI: begin
                        s_d.ime = 1'b0;
                        s_d     = finish(s_d);
                    end
                    OP_INC_A: begin
                        s_d.a     = inc_res;
                        s_d.flags = inc_flags;
                        s_d       = finish(s_d);
                    end
                    OP_JP_HL: begin
                        s_d.pc = {s_q.h, s_q.l};
                        s_d    = finish(s_d);
                    end
                    OP_LD_HL, OP_LD_SP, OP_JP_IMM, OP_CALL: begin
                        s_d.pc    = s_q.pc + 16'd1;
                        s_d.state = ST_IMM_LO;
                    end
                    OP_PREFIX: begin
                        s_d.pc    = s_q.pc + 16'd1;
                        s_d.state = ST_CB_DEC;
                    end
                    default: s_d.state = ST_TRAP;
                endcase
            end
            ST_IMM_LO: begin
                s_d.imm_lo = mem_rdata;
                s_d.pc     = s_q.pc + 16'd1;
                s_d.state  = ST_IMM_HI;
            end
            ST_IMM_HI: begin
                unique case (s_q.op)
                    OP_LD_HL: begin
                        s_d.l = s_q.imm_lo;
                        s_d.h = mem_rdata;
                        s_d   = finish(s_d);
                    end
                    OP_LD_SP: begin
                        s_d.sp = {mem_rdata, s_q.imm_lo};
                        s_d    = finish(s_d);
                    end
                    OP_JP_IMM: begin
                        s_d.pc = {mem_rdata, s_q.imm_lo};
                        s_d    = finish(s_d);
                    end
                    OP_CALL: begin
                        s_d.imm_hi = mem_rdata;
                        s_d.state  = ST_PUSH_HI;
                    end
                    default: s_d.state = ST_TRAP;
                endcase
            end
            ST_PUSH_HI: begin
                s_d.sp    = s_q.sp - 16'd1;
                s_d.state = ST_PUSH_LO;
            end
            ST_PUSH_LO: begin
                s_d.sp = s_q.sp - 16'd1;
                s_d.pc = {s_q.imm_hi, s_q.imm_lo};
                s_d    = finish(s_d);
            end
            ST_CB_DEC: s_d.state = dec_bit7 ? ST_BIT_ADDR : ST_TRAP;
            ST_BIT_ADDR: s_d.state = ST_BIT_EXE;
            ST_BIT_EXE: begin
                s_d.flags = bit_flags;
                s_d       = finish(s_d);
            end
            default: s_d.state = ST_TRAP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.state     <= ST_FETCH;
            s_q.op        <= OP_NOP;
            s_q.pc        <= RESET_PC;
            s_q.sp        <= RESET_SP;
            s_q.ipc       <= RESET_PC;
            s_q.retire_pc <= RESET_PC;
            s_q.ime       <= RESET_IME;
        end else begin
            s_q <= s_d;
        end
    end

    assign retire    = s_q.retire;
    assign retire_pc = s_q.retire_pc;
    assign fault     = (s_q.state == ST_TRAP);
    assign a_out     = s_q.a;
    assign f_out     = {s_q.flags, {FLAG_PAD{1'b0}}};
    assign hl_out    = {s_q.h, s_q.l};
    assign sp_out    = s_q.sp;
    assign ime_out   = s_q.ime;

endmodule

// File: rtl/tiny8_core_chk.sv
module tiny8_core_chk
    import tiny8_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              retire,
    input logic              fault,
    input logic [ADDR_W-1:0] sp_out
);

    // R9: the trap state is never left without reset
    p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    // R9: nothing retires and nothing is written while trapped
    p_fault_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!retire && !mem_we));

    // R10: every instruction spans at least two cycles, so a pulse is isolated
    p_retire_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !retire);

    // R7: a push begins with the high byte and is followed one address lower
    p_push_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !$past(mem_we)) |=> (mem_we && (mem_addr == $past(mem_addr) - 16'd1)));

    // R7: after the last push write, SP points at the byte just written
    p_push_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we) |-> (sp_out == $past(mem_addr)));

    // R7: the first push write lands just below the stack pointer
    p_push_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !$past(mem_we)) |-> (mem_addr == sp_out - 16'd1));

endmodule

bind tiny8_core tiny8_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .retire   (retire),
    .fault    (fault),
    .sp_out   (sp_out)
);

// File: tb/tiny8_core_bench.sv
module tiny8_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        retire;
    logic [15:0] retire_pc;
    logic        fault;
    logic [7:0]  a_out;
    logic [7:0]  f_out;
    logic [15:0] hl_out;
    logic [15:0] sp_out;
    logic        ime_out;

    int checks = 0;
    int errors = 0;

    // Bus memory driven by the core, and the model's own copy
    logic [7:0] mem     [logic [15:0]];
    logic [7:0] ref_mem [logic [15:0]];

    // Model state
    logic [7:0]  ra, rf, rh, rl;
    logic [15:0] rpc, rsp;
    logic        rime;

    always #10 clk = ~clk;

    tiny8_core u_tiny8_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .retire    (retire),
        .retire_pc (retire_pc),
        .fault     (fault),
        .a_out     (a_out),
        .f_out     (f_out),
        .hl_out    (hl_out),
        .sp_out    (sp_out),
        .ime_out   (ime_out)
    );

    always @(posedge clk) begin
        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
        if (mem_we) mem[mem_addr] = mem_wdata;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] rdm(input logic [15:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    endfunction

    task automatic put(input logic [15:0] a, input logic [7:0] b);
        mem[a]     = b;
        ref_mem[a] = b;
    endtask

    task automatic clear_mem();
        mem.delete();
        ref_mem.delete();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ra = 8'h00; rf = 8'h00; rh = 8'h00; rl = 8'h00;
        rpc = 16'h0100; rsp = 16'hDFFF; rime = 1'b1;
    endtask

    // Reference model: executes one instruction from the requirements
    task automatic iss_step(output bit bad, output string req, output logic [15:0] ipc);
        logic [7:0]  op, b1, b2, v;
        logic [15:0] ret;
        bad = 1'b0;
        ipc = rpc;
        op  = rdm(rpc);
        b1  = rdm(rpc + 16'd1);
        b2  = rdm(rpc + 16'd2);
        case (op)
            8'h00: begin rpc = rpc + 16'd1; req = "R2"; end
            8'hF3: begin rime = 1'b0; rpc = rpc + 16'd1; req = "R2"; end
            8'h3C: begin
                ra  = ra + 8'd1;
                rf  = {(ra == 8'h00), 1'b0, (ra[3:0] == 4'h0), rf[4], 4'h0};
                rpc = rpc + 16'd1; req = "R5";
            end
            8'h21: begin rl = b1; rh = b2; rpc = rpc + 16'd3; req = "R3"; end
            8'h31: begin rsp = {b2, b1}; rpc = rpc + 16'd3; req = "R4"; end
            8'hC3: begin rpc = {b2, b1}; req = "R6"; end
            8'hE9: begin rpc = {rh, rl}; req = "R6"; end
            8'hCD: begin
                ret = rpc + 16'd3;
                rsp = rsp - 16'd1; ref_mem[rsp] = ret[15:8];
                rsp = rsp - 16'd1; ref_mem[rsp] = ret[7:0];
                rpc = {b2, b1}; req = "R7";
            end
            8'hCB: begin
                if (b1 == 8'h7E) begin
                    v   = rdm({rh, rl});
                    rf  = {~v[7], 1'b0, 1'b1, rf[4], 4'h0};
                    rpc = rpc + 16'd2; req = "R8";
                end else begin
                    bad = 1'b1; req = "R9";
                end
            end
            default: begin bad = 1'b1; req = "R9"; end
        endcase
    endtask

    // Step the model and the core side by side; stop at a trap
    task automatic run_cmp(input int n);
        bit          bad;
        string       req;
        logic [15:0] ipc;
        bit          seen;
        for (int i = 0; i < n; i++) begin
            iss_step(bad, req, ipc);
            if (bad) begin
                seen = 1'b0;
                for (int k = 0; k < 8 && !seen; k++) begin
                    @(negedge clk);
                    seen = fault;
                end
                chk(seen, "R9", "fault raised", {31'd0, fault}, 32'd1);
                seen = 1'b0;
                for (int k = 0; k < 16; k++) begin
                    @(negedge clk);
                    if (retire || mem_we || !fault) seen = 1'b1;
                end
                chk(!seen, "R9", "trap stays quiet", {31'd0, seen}, 32'd0);
                return;
            end
            seen = 1'b0;
            for (int k = 0; k < 16 && !seen; k++) begin
                @(negedge clk);
                seen = retire;
            end
            chk(seen, "R10", "retire seen", {31'd0, seen}, 32'd1);
            if (!seen) return;
            chk(retire_pc == ipc, "R10", "retire_pc", retire_pc, ipc);
            chk(a_out == ra,   req, "acc",   a_out,  ra);
            chk(f_out == rf,   req, "flags", f_out,  rf);
            chk(hl_out == {rh, rl}, req, "hl", hl_out, {rh, rl});
            chk(sp_out == rsp, req, "sp",    sp_out, rsp);
            chk(ime_out == rime, req, "ime", ime_out, rime);
        end
    endtask

    logic [15:0] pp;
    int          cnt;

    task automatic emit(input logic [7:0] b);
        put(pp, b);
        pp = pp + 16'd1;
    endtask

    // Seeded random program of supported opcodes; every control transfer lands on the next instruction
    task automatic gen_random(input int n);
        logic [15:0] t;
        int          k;
        clear_mem();
        for (int i = 0; i < 16; i++) put(16'h8000 + 16'(i), 8'($urandom));
        pp  = 16'h0100;
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            k = $urandom_range(0, 9);
            case (k)
                0: begin emit(8'h00); cnt++; end
                1: begin emit(8'hF3); cnt++; end
                2, 3: begin emit(8'h3C); cnt++; end
                4: begin emit(8'h21); emit(8'($urandom)); emit(8'($urandom)); cnt++; end
                5: begin emit(8'h31); emit(8'($urandom));
                         emit(8'($urandom_range(8'hC0, 8'hDF))); cnt++; end
                6: begin t = pp + 16'd3; emit(8'hC3); emit(t[7:0]); emit(t[15:8]); cnt++; end
                7: begin t = pp + 16'd3; emit(8'hCD); emit(t[7:0]); emit(t[15:8]); cnt++; end
                8: begin emit(8'h21); emit(8'($urandom_range(0, 15))); emit(8'h80);
                         emit(8'hCB); emit(8'h7E); cnt += 2; end
                default: begin t = pp + 16'd4; emit(8'h21); emit(t[7:0]); emit(t[15:8]);
                         emit(8'hE9); cnt += 2; end
            endcase
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));

        // R1: reset state, sampled before the first edge after release
        clear_mem();
        put(16'h0100, 8'h00);
        do_reset();
        chk(mem_addr == 16'h0100, "R1", "first fetch address", mem_addr, 16'h0100);
        chk(sp_out == 16'hDFFF, "R1", "sp", sp_out, 16'hDFFF);
        chk(a_out == 8'h00 && f_out == 8'h00 && hl_out == 16'h0000, "R1", "acc/flags/hl",
            {a_out, f_out, hl_out}, 32'h0);
        chk(ime_out == 1'b1, "R1", "ime", {31'd0, ime_out}, 32'd1);
        chk(!retire && !mem_we && !fault, "R1", "strobes low",
            {29'd0, retire, mem_we, fault}, 32'd0);
        run_cmp(1);

        // R5: full accumulator wrap, covering 0x0F->0x10 and 0xFF->0x00
        clear_mem();
        for (int i = 0; i < 256; i++) put(16'h0100 + 16'(i), 8'h3C);
        do_reset();
        run_cmp(256);
        chk(a_out == 8'h00 && f_out == 8'hA0, "R5", "after wrap", {a_out, f_out}, 16'h00A0);

        // R7 R4 R11: call with a known stack pointer, then memory contents
        clear_mem();
        put(16'h0100, 8'h31); put(16'h0101, 8'h00); put(16'h0102, 8'hD0);
        put(16'h0103, 8'hCD); put(16'h0104, 8'h34); put(16'h0105, 8'h12);
        put(16'h1234, 8'h00);
        do_reset();
        run_cmp(3);
        chk(mem.exists(16'hCFFF) && mem[16'hCFFF] == 8'h01, "R7", "pushed high byte",
            mem.exists(16'hCFFF) ? mem[16'hCFFF] : 8'hXX, 8'h01);
        chk(mem.exists(16'hCFFE) && mem[16'hCFFE] == 8'h06, "R7", "pushed low byte",
            mem.exists(16'hCFFE) ? mem[16'hCFFE] : 8'hXX, 8'h06);

        // R8: bit test on a byte with bit 7 clear, then set
        clear_mem();
        put(16'h4000, 8'h7F); put(16'h4001, 8'h80);
        put(16'h0100, 8'h21); put(16'h0101, 8'h00); put(16'h0102, 8'h40);
        put(16'h0103, 8'hCB); put(16'h0104, 8'h7E);
        put(16'h0105, 8'h21); put(16'h0106, 8'h01); put(16'h0107, 8'h40);
        put(16'h0108, 8'hCB); put(16'h0109, 8'h7E);
        do_reset();
        run_cmp(2);
        chk(f_out == 8'hA0, "R8", "bit7 clear flags", f_out, 8'hA0);
        run_cmp(2);
        chk(f_out == 8'h20, "R8", "bit7 set flags", f_out, 8'h20);

        // R6 R2: jump through HL and interrupt disable
        clear_mem();
        put(16'h0100, 8'h21); put(16'h0101, 8'h00); put(16'h0102, 8'h03);
        put(16'h0103, 8'hE9); put(16'h0300, 8'hF3); put(16'h0301, 8'h00);
        do_reset();
        run_cmp(4);
        chk(ime_out == 1'b0, "R2", "ime after di", {31'd0, ime_out}, 32'd0);

        // R9: undefined first-page opcode after a good one
        clear_mem();
        put(16'h0100, 8'h3C); put(16'h0101, 8'hD3);
        do_reset();
        run_cmp(2);

        // R9: undefined second-page opcode
        clear_mem();
        put(16'h0100, 8'hCB); put(16'h0101, 8'h11);
        do_reset();
        run_cmp(1);

        // R3 R4 R6 R7 R8 R10 R11: seeded random programs
        for (int s = 0; s < 4; s++) begin
            gen_random(150);
            do_reset();
            run_cmp(cnt);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule